// File: doc/BRIEF.md
# Dual-Bus Memory Access Arbiter with Refresh Scheduling

This block sits in front of a memory array that two independent buses share. A fast processor-side bus and a general system bus each present an address and a 2-bit cycle code. An internal refresh generator competes with them when the array is built from dynamic cells. One access runs at a time. The winner's address is loaded into the memory-address register. The block then steps through an optional precharge phase and an access phase, and ends with a completion handshake back to the bus that owns the cycle.

The fast bus uses a request level and gets back a one-cycle done pulse. The system bus uses a master sync level. The block answers it with a slave sync that stays high until the master lets its sync go. A read-and-pause cycle locks the array to the bus that issued it until that bus writes back. The following write then skips the precharge phase. With the mode flag low (static memory), refresh stops and precharge is never inserted.

Top module: `mem_access_arbiter`

## Requirements
- R1: The three grant outputs are never high together. A grant rises when its access starts and stays high to the end of the handshake. While a bus grant is high, `mar` holds the address that bus presented when it won. Reset clears all grants, strobes, `mar` and the late flag.
- R2: With `dyn_mode` high, a refresh comes due once every PERIOD_CYC/ROWS cycles, so ROWS refreshes fall in each PERIOD_CYC window of an idle array. Successive refreshes drive row numbers 0, 1, ... ROWS-1 and then wrap to 0, in the low bits of `mar`, with all upper bits zero.
- R3: With `dyn_mode` low, no refresh is started and `ref_late` stays low.
- R4: When more than one source is waiting at an idle cycle, a due refresh wins over the fast bus, and the fast bus wins over the system bus.
- R5: Cycle code 00 is a read and 01 is a read-and-pause: each raises `data_latch` for one cycle, the last access cycle, and never `mem_we`. Code 10 is a word write: `mem_we` is high for all ACC_CYC access cycles and `mem_byte` stays low. Code 11 is a byte write: it behaves like 10, but `mem_byte` is high together with `mem_we`.
- R6: With `dyn_mode` high, every bus access first spends PRE_CYC cycles with `mem_pre` high. With `dyn_mode` low, there is no precharge phase.
- R7: After a bus completes a read-and-pause, no other bus and no refresh is granted until that same bus completes a write (10 or 11). That write has no precharge phase.
- R8: A fast-bus access keeps the grant for PRE_CYC (if precharged) + ACC_CYC + 1 cycles. `fb_done` is high only in the last of these cycles. `sys_inhibit` is high throughout that grant, and the system bus is neither granted nor acknowledged in that time.
- R9: A system-bus access raises `sb_ssync` once the precharge and access cycles are done. `sb_ssync` stays high while `sb_msync` stays high. The grant and `sb_ssync` drop in the cycle after `sb_msync` falls.
- R10: If a refresh slot expires while the previous due refresh has not yet started, `ref_late` rises. It clears when a refresh is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dyn_mode | input | 1 | 1 = dynamic array (refresh and precharge), 0 = static array |
| fb_req | input | 1 | Fast-bus request level |
| fb_addr | input | AW | Fast-bus address |
| fb_ctl | input | 2 | Fast-bus cycle code |
| fb_grant | output | 1 | Fast bus owns the array |
| fb_done | output | 1 | Fast-bus completion pulse |
| sys_inhibit | output | 1 | System-bus addressing blocked by a fast access |
| sb_msync | input | 1 | System-bus master sync |
| sb_addr | input | AW | System-bus address |
| sb_ctl | input | 2 | System-bus cycle code |
| sb_grant | output | 1 | System bus owns the array |
| sb_ssync | output | 1 | System-bus slave sync |
| rf_grant | output | 1 | Refresh cycle in progress |
| ref_late | output | 1 | A refresh slot expired before the last due refresh started |
| mar | output | AW | Memory-address register |
| mem_pre | output | 1 | Precharge phase |
| mem_we | output | 1 | Write strobe |
| mem_byte | output | 1 | Byte-write qualifier |
| data_latch | output | 1 | Read-data latch strobe |

## Verification
Two collisions are the focus. The first is a refresh slot falling due while a bus request is also waiting. The bench provokes it by holding a system cycle in its handshake, or by holding a read-and-pause lock, past two refresh slots while the other bus is already requesting. When the array is released, the refresh grant must rise first and the late flag must clear in that same cycle. The second is a fast request and a system sync raised on the same edge. Here the fast grant must come first and the system access must follow with its own full timing. Randomly mixed cycle codes and buses, in both memory modes, are checked for timing, strobes and lock behaviour against values the bench computes.

// File: rtl/mem_access_arbiter.sv
module mem_access_arbiter #(
  parameter int AW         = 16,
  parameter int ROWS       = 32,
  parameter int PERIOD_CYC = 50000,
  parameter int PRE_CYC    = 2,
  parameter int ACC_CYC    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dyn_mode,
  input  logic          fb_req,
  input  logic [AW-1:0] fb_addr,
  input  logic [1:0]    fb_ctl,
  output logic          fb_grant,
  output logic          fb_done,
  output logic          sys_inhibit,
  input  logic          sb_msync,
  input  logic [AW-1:0] sb_addr,
  input  logic [1:0]    sb_ctl,
  output logic          sb_grant,
  output logic          sb_ssync,
  output logic          rf_grant,
  output logic          ref_late,
  output logic [AW-1:0] mar,
  output logic          mem_pre,
  output logic          mem_we,
  output logic          mem_byte,
  output logic          data_latch
);

  localparam int RB   = $clog2(ROWS);
  localparam int SLOT = PERIOD_CYC / ROWS;
  localparam int SW   = $clog2(SLOT);
  localparam int MAXC = (PRE_CYC > ACC_CYC) ? PRE_CYC : ACC_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [1:0] O_RF = 2'd0;
  localparam logic [1:0] O_FB = 2'd1;
  localparam logic [1:0] O_SB = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACC, S_FIN} st_t;

  st_t           st;
  logic [1:0]    own;
  logic [1:0]    cyc;
  logic [CW-1:0] cnt;
  logic [SW-1:0] slot;
  logic [RB-1:0] row;
  logic          ref_due;
  logic          lock_on;
  logic [1:0]    lock_src;

  logic       idle, tick, go_rf, go_fb, go_sb, skip_pre, fin_exit;
  logic [1:0] win_ctl;

  assign idle     = (st == S_IDLE);
  assign tick     = dyn_mode && (slot == SW'(SLOT - 1));
  assign go_rf    = idle && dyn_mode && ref_due && !lock_on;
  assign go_fb    = idle && !go_rf && fb_req && (!lock_on || lock_src == O_FB);
  assign go_sb    = idle && !go_rf && !go_fb && sb_msync && (!lock_on || lock_src == O_SB);
  assign win_ctl  = go_fb ? fb_ctl : sb_ctl;
  assign skip_pre = !dyn_mode || (lock_on && win_ctl[1]);
  assign fin_exit = (st == S_FIN) && !(own == O_SB && sb_msync);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot     <= '0;
      ref_due  <= 1'b0;
      ref_late <= 1'b0;
    end else begin
      slot     <= (!dyn_mode || tick) ? '0 : slot + 1'b1;
      ref_due  <= !dyn_mode ? 1'b0 : tick ? 1'b1 : go_rf ? 1'b0 : ref_due;
      ref_late <= !dyn_mode ? 1'b0 : (tick && ref_due && !go_rf) ? 1'b1 :
                  go_rf ? 1'b0 : ref_late;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      own      <= O_RF;
      cyc      <= 2'b00;
      cnt      <= '0;
      mar      <= '0;
      row      <= '0;
      lock_on  <= 1'b0;
      lock_src <= O_RF;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (go_rf) begin
            own <= O_RF;
            cyc <= 2'b00;
            mar <= {{(AW - RB){1'b0}}, row};
            row <= (row == RB'(ROWS - 1)) ? '0 : row + 1'b1;
            st  <= S_PRE;
            cnt <= CW'(PRE_CYC - 1);
          end else if (go_fb || go_sb) begin
            own <= go_fb ? O_FB : O_SB;
            cyc <= win_ctl;
            mar <= go_fb ? fb_addr : sb_addr;
            st  <= skip_pre ? S_ACC : S_PRE;
            cnt <= skip_pre ? CW'(ACC_CYC - 1) : CW'(PRE_CYC - 1);
          end
        end
        S_PRE: begin
          if (cnt == '0) begin
            st  <= S_ACC;
            cnt <= CW'(ACC_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ACC: begin
          if (cnt == '0) st <= S_FIN;
          else           cnt <= cnt - 1'b1;
        end
        S_FIN: begin
          if (fin_exit) begin
            st <= S_IDLE;
            if (own != O_RF) begin
              if (cyc == 2'b01) begin
                lock_on  <= 1'b1;
                lock_src <= own;
              end else if (cyc[1]) begin
                lock_on  <= 1'b0;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign fb_grant    = !idle && own == O_FB;
  assign sb_grant    = !idle && own == O_SB;
  assign rf_grant    = !idle && own == O_RF;
  assign sys_inhibit = fb_grant;
  assign fb_done     = (st == S_FIN) && own == O_FB;
  assign sb_ssync    = (st == S_FIN) && own == O_SB;
  assign mem_pre     = (st == S_PRE);
  assign mem_we      = (st == S_ACC) && own != O_RF && cyc[1];
  assign mem_byte    = mem_we && cyc[0];
  assign data_latch  = (st == S_ACC) && cnt == '0 && own != O_RF && !cyc[1];

endmodule

// File: rtl/mem_access_arbiter_chk.sv
module mem_access_arbiter_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dyn_mode,
  input logic          fb_grant,
  input logic          sb_grant,
  input logic          rf_grant,
  input logic          fb_done,
  input logic          sb_ssync,
  input logic          sb_msync,
  input logic          sys_inhibit,
  input logic          mem_we,
  input logic          mem_byte,
  input logic          mem_pre,
  input logic          data_latch,
  input logic          ref_late,
  input logic [AW-1:0] mar
);

  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fb_grant, sb_grant, rf_grant}));

  p_mar_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fb_grant) && fb_grant |-> $stable(mar));

  p_static_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dyn_mode && !$past(dyn_mode) |-> !$rose(rf_grant) && !ref_late);

  p_write_in_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (fb_grant || sb_grant) && !mem_pre && !data_latch);

  p_byte_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_byte |-> mem_we);

  p_latch_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_latch |=> !data_latch);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_done |=> !fb_done);

  p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_inhibit |-> !sb_grant && !sb_ssync);

  p_ssync_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sb_ssync && sb_msync |=> sb_ssync);

endmodule

bind mem_access_arbiter mem_access_arbiter_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_mem_access_arbiter.sv
module sim_mem_access_arbiter;
  localparam int AW = 16, ROWS = 32, PERIOD = 640, PRE = 2, ACC = 3;
  localparam int SLOT = PERIOD / ROWS;

  logic clk = 0, rst_n = 0, dyn_mode = 1;
  logic fb_req = 0, sb_msync = 0;
  logic [AW-1:0] fb_addr = '0, sb_addr = '0;
  logic [1:0] fb_ctl = 0, sb_ctl = 0;
  logic fb_grant, fb_done, sys_inhibit, sb_grant, sb_ssync, rf_grant, ref_late;
  logic mem_pre, mem_we, mem_byte, data_latch;
  logic [AW-1:0] mar;

  int n_chk = 0, n_fail = 0, rf_cnt = 0, exp_row = 0, lock_who = 0;
  logic rf_prev = 0;

  always #10 clk = ~clk;

  mem_access_arbiter #(.AW(AW), .ROWS(ROWS), .PERIOD_CYC(PERIOD),
                       .PRE_CYC(PRE), .ACC_CYC(ACC)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int pre_exp(input int bus, input logic [1:0] ctl);
    if (!dyn_mode) return 0;
    return (lock_who == bus && ctl[1]) ? 0 : PRE;
  endfunction

  function automatic void lock_upd(input int bus, input logic [1:0] ctl);
    if (ctl == 2'b01) lock_who = bus;
    else if (ctl[1] && lock_who == bus) lock_who = 0;
  endfunction

  // R2: refresh row sequence seen at the ports
  always @(negedge clk) begin
    if (rst_n && rf_grant && !rf_prev) begin
      chk(int'(mar) == exp_row, "R2 refresh row", int'(mar), exp_row);
      exp_row = (exp_row + 1) % ROWS;
      rf_cnt++;
    end
    rf_prev = rf_grant;
  end

  task automatic fast_xfer(input logic [AW-1:0] a, input logic [1:0] c);
    int ep, t, ng, np, nw, nb, nl, nd;
    bit inh_ok;
    ep = pre_exp(1, c);
    t = 0; ng = 0; np = 0; nw = 0; nb = 0; nl = 0; nd = 0; inh_ok = 1;
    @(negedge clk); fb_addr = a; fb_ctl = c; fb_req = 1;
    while (!fb_grant) begin
      @(negedge clk); t++;
      if (t > 3000) begin chk(0, "R1 fast grant timeout", t, 0); fb_req = 0; return; end
    end
    chk(mar == a, "R1 fast mar", int'(mar), int'(a));
    do begin
      ng++; np += int'(mem_pre); nw += int'(mem_we); nb += int'(mem_byte);
      nl += int'(data_latch);
      if (!sys_inhibit) inh_ok = 0;
      if (fb_done) begin nd++; fb_req = 0; end
      @(negedge clk);
    end while (fb_grant);
    chk(np == ep, "R6 fast precharge cycles", np, ep);
    chk(ng == ep + ACC + 1, "R8 fast grant length", ng, ep + ACC + 1);
    chk(nd == 1, "R8 fast done pulse", nd, 1);
    chk(inh_ok, "R8 inhibit during fast", 0, 1);
    chk(nw == (c[1] ? ACC : 0), "R5 fast write strobe", nw, c[1] ? ACC : 0);
    chk(nb == (c == 2'b11 ? ACC : 0), "R5 fast byte qual", nb, c == 2'b11 ? ACC : 0);
    chk(nl == (c[1] ? 0 : 1), "R5 fast read latch", nl, c[1] ? 0 : 1);
    lock_upd(1, c);
  endtask

  task automatic sys_xfer(input logic [AW-1:0] a, input logic [1:0] c, input int hold);
    int ep, t, ng, np, nw, nb, nl;
    bit held;
    ep = pre_exp(2, c);
    t = 0; ng = 0; np = 0; nw = 0; nb = 0; nl = 0; held = 1;
    @(negedge clk); sb_addr = a; sb_ctl = c; sb_msync = 1;
    while (!sb_grant) begin
      @(negedge clk); t++;
      if (t > 3000) begin chk(0, "R1 system grant timeout", t, 0); sb_msync = 0; return; end
    end
    chk(mar == a, "R1 system mar", int'(mar), int'(a));
    while (!sb_ssync && t < 6000) begin
      ng++; np += int'(mem_pre); nw += int'(mem_we); nb += int'(mem_byte);
      nl += int'(data_latch); t++;
      @(negedge clk);
    end
    chk(ng == ep + ACC, "R9 cycles before slave sync", ng, ep + ACC);
    chk(np == ep, "R6 system precharge cycles", np, ep);
    chk(nw == (c[1] ? ACC : 0), "R5 system write strobe", nw, c[1] ? ACC : 0);
    chk(nb == (c == 2'b11 ? ACC : 0), "R5 system byte qual", nb, c == 2'b11 ? ACC : 0);
    chk(nl == (c[1] ? 0 : 1), "R5 system read latch", nl, c[1] ? 0 : 1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!sb_ssync || !sb_grant) held = 0;
    end
    chk(held, "R9 slave sync held", 0, 1);
    sb_msync = 0;
    @(negedge clk);
    chk(!sb_grant && !sb_ssync, "R9 release after sync drop", int'(sb_grant), 0);
    lock_upd(2, c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int r0, bus;
    logic [1:0] c;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk(!fb_grant && !sb_grant && !rf_grant && mar == '0 && !ref_late && !mem_we &&
        !mem_pre && !data_latch, "R1 reset state", int'(mar), 0);
    rst_n = 1;

    // R2: refresh rate on an idle dynamic array
    repeat (5) @(negedge clk);
    r0 = rf_cnt;
    repeat (PERIOD) @(negedge clk);
    chk(rf_cnt - r0 >= ROWS - 1 && rf_cnt - r0 <= ROWS + 1, "R2 refreshes per period",
        rf_cnt - r0, ROWS);

    // R4: fast and system requests in the same cycle
    fork
      fast_xfer(16'h1234, 2'b00);
      sys_xfer(16'hBEEF, 2'b10, 0);
      begin
        @(negedge clk); @(negedge clk);
        while (!fb_grant && !sb_grant) @(negedge clk);
        chk(fb_grant && !sb_grant, "R4 fast over system", int'(sb_grant), 0);
      end
    join

    // R7 and R10: read-pause lock blocks system bus and refresh
    fast_xfer(16'h0F0F, 2'b01);
    fork
      sys_xfer(16'h7777, 2'b00, 0);
      begin
        bit blocked = 1;
        for (int i = 0; i < 3 * SLOT; i++) begin
          @(negedge clk);
          if (sb_grant || rf_grant) blocked = 0;
        end
        chk(blocked, "R7 lock blocks others", 0, 1);
        chk(ref_late, "R10 late flag under lock", int'(ref_late), 1);
        fast_xfer(16'h0F0F, 2'b10);
        while (!rf_grant && !sb_grant) @(negedge clk);
        chk(rf_grant, "R4 refresh over waiting system", int'(rf_grant), 1);
        chk(!ref_late, "R10 late cleared on refresh", int'(ref_late), 0);
      end
    join

    // R9 and R10: system handshake held open across refresh slots
    sys_xfer(16'h4242, 2'b11, 2 * SLOT + 10);
    chk(ref_late, "R10 late flag after long hold", int'(ref_late), 1);
    @(negedge clk);
    chk(rf_grant && !ref_late, "R4 refresh first after release", int'(rf_grant), 1);
    while (rf_grant) @(negedge clk);

    // random mix, dynamic mode
    for (int i = 0; i < 60; i++) begin
      bus = (lock_who != 0) ? lock_who : 1 + int'($urandom % 2);
      c = 2'($urandom % 4);
      if (bus == 1) fast_xfer(AW'($urandom), c);
      else sys_xfer(AW'($urandom), c, int'($urandom % 4));
    end

    // R3: static mode
    while (rf_grant) @(negedge clk);
    dyn_mode = 0;
    r0 = rf_cnt;
    repeat (4 * SLOT) @(negedge clk);
    chk(rf_cnt == r0, "R3 no refresh in static mode", rf_cnt - r0, 0);
    chk(!ref_late, "R3 late flag low in static mode", int'(ref_late), 0);
    for (int i = 0; i < 30; i++) begin
      bus = (lock_who != 0) ? lock_who : 1 + int'($urandom % 2);
      c = 2'($urandom % 4);
      if (bus == 1) fast_xfer(AW'($urandom), c);
      else sys_xfer(AW'($urandom), c, int'($urandom % 3));
    end
    chk(rf_cnt == r0, "R3 no refresh during static traffic", rf_cnt - r0, 0);
    report();
  end
endmodule